// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes an 8-bit word between an A-side bus and a B-side bus. Each side has its own capture register. Each side also has a separate input, a separate output and an output-enable signal, so it can sit inside a chip that has no tri-state nets. Capture strobes `cap_a` and `cap_b` are one cycle wide and are sampled on the system clock. A strobe loads the *resolved* value of its bus. On a side that is being driven, the resolved value is the block's own output. On a side that is not driven, it is the external input. A strobe loads whatever the select and enable inputs are.

Each direction has a select input that chooses its data:

- `sel_a2b` picks what the B side receives: live A data when 0, or the stored A register when 1.
- `sel_b2a` picks what the A side receives: live B data when 0, or the stored B register when 1.

The enables have mixed polarity:

- `en_b` is active high and drives the B side.
- `en_a_n` is active low and drives the A side.

Because the register loads the resolved value, a register can copy the opposite side's data through loopback. When both sides drive live data into each other, the pair latches and keeps the last value.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both capture registers and the latch value are cleared to zero. After reset, stored-data output shows 0x00 on both sides.
- R2: A cycle with `cap_a` high loads the resolved A value into the A register, and `cap_b` loads the resolved B value into the B register. This happens for any select and enable setting. With both sides isolated, the resolved value is the external input.
- R3: With `en_b` high, `b_out` equals the resolved A value when `sel_a2b` is 0, and the A register when `sel_a2b` is 1.
- R4: With `en_a_n` low, `a_out` equals the resolved B value when `sel_b2a` is 0, and the B register when `sel_b2a` is 1.
- R5: `b_oe` equals `en_b`, and `a_oe` equals the inverse of `en_a_n`. An output whose enable is inactive reads 0x00.
- R6: The resolved value of a side is its own output while that side is driven, and its input otherwise. Outputs follow this rule for every control combination.
- R7: With both sides driven and both selects 0, both outputs show the resolved A value from the previous cycle. They keep showing it while the mode lasts, and both inputs are ignored.
- R8: Loopback copies data. With B driven live from an undriven A side, `cap_b` loads A's input into the B register. The mirror case loads B's input into the A register.
- R9: With both sides driven from their stored registers, strobing `cap_a` and `cap_b` in the same cycle swaps the old register contents.
- R10: With both sides driven and both selects 1, the A register appears on `b_out` and the B register appears on `a_out` at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 8 | Value seen on the A bus from outside |
| b_in | input | 8 | Value seen on the B bus from outside |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| sel_a2b | input | 1 | B-side data source: 0 live A, 1 stored A |
| sel_b2a | input | 1 | A-side data source: 0 live B, 1 stored B |
| en_b | input | 1 | Drive B side, active high |
| en_a_n | input | 1 | Drive A side, active low |
| a_out | output | 8 | Data driven onto the A bus |
| a_oe | output | 1 | A bus driven |
| b_out | output | 8 | Data driven onto the B bus |
| b_oe | output | 1 | B bus driven |

## Verification
The assertions assume that the strobes and controls are synchronous to `clk` and stable during each cycle. They also assume that a strobe lasts one cycle, so each capture lands one edge later. The latch check assumes that nothing outside breaks the latch while it lasts. The model in this block ignores external inputs in that mode, and random stimulus may toggle those inputs freely. Random stimulus changes all inputs only between edges. Directed steps force the narrow modes: loopback, simultaneous strobes with stored selects, and latching.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic         en_b,
  input  logic         en_a_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] reg_a, reg_b, hold_q;
  logic [W-1:0] a_res, b_res;
  logic         a_drv, b_drv;

  assign a_drv = ~en_a_n;
  assign b_drv = en_b;

  // loop-free resolution; the mutual-live case falls back to the latch
  assign a_res = !a_drv   ? a_in  :
                 sel_b2a  ? reg_b :
                 !b_drv   ? b_in  :
                 sel_a2b  ? reg_a : hold_q;

  assign b_res = !b_drv   ? b_in  :
                 sel_a2b  ? reg_a :
                 !a_drv   ? a_in  :
                 sel_b2a  ? reg_b : hold_q;

  assign a_oe  = a_drv;
  assign b_oe  = b_drv;
  assign a_out = a_drv ? a_res : '0;
  assign b_out = b_drv ? b_res : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a  <= '0;
      reg_b  <= '0;
      hold_q <= '0;
    end else begin
      hold_q <= a_res;
      if (cap_a) reg_a <= a_res;
      if (cap_b) reg_b <= b_res;
    end
  end

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         cap_a,
  input logic         cap_b,
  input logic         sel_a2b,
  input logic         sel_b2a,
  input logic         en_b,
  input logic         en_a_n,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b
);

  logic rein;
  assign rein = !en_a_n && en_b && !sel_a2b && !sel_b2a;

  assert_cap_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && en_a_n) |=> reg_a == $past(a_in));
  assert_cap_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b && !en_b) |=> reg_b == $past(b_in));
  assert_stored_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_b && sel_a2b && $past(en_b && sel_a2b && !cap_a)) |-> $stable(b_out));
  assert_stored_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_n && sel_b2a && $past(!en_a_n && sel_b2a && !cap_b)) |-> $stable(a_out));
  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rein && $past(rein)) |-> ($stable(a_out) && a_out == b_out));
  assert_loop_ab_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b && en_b && !sel_a2b && en_a_n) |=> reg_b == $past(a_in));
  assert_loop_ba_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && !en_a_n && !sel_b2a && !en_b) |=> reg_a == $past(b_in));
  assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && cap_b && en_b && !en_a_n && sel_a2b && sel_b2a)
      |=> (reg_a == $past(reg_b) && reg_b == $past(reg_a)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .cap_a(cap_a), .cap_b(cap_b), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
  .en_b(en_b), .en_a_n(en_a_n), .a_out(a_out), .b_out(b_out),
  .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic       cap_a = 0, cap_b = 0, sel_a2b = 0, sel_b2a = 0, en_b = 0, en_a_n = 1;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;

  int errors = 0, checks = 0;
  logic [7:0] m_ra = 0, m_rb = 0, m_hold = 0;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .cap_a(cap_a), .cap_b(cap_b), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .en_b(en_b), .en_a_n(en_a_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [7:0] exp_a_res();
    if (en_a_n) return a_in;
    if (sel_b2a) return m_rb;
    if (!en_b) return b_in;
    if (sel_a2b) return m_ra;
    return m_hold;
  endfunction

  function automatic logic [7:0] exp_b_res();
    if (!en_b) return b_in;
    if (sel_a2b) return m_ra;
    if (en_a_n) return a_in;
    if (sel_b2a) return m_rb;
    return m_hold;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(string req, logic [7:0] ai, logic [7:0] bi, logic ca, logic cb,
                      logic sab, logic sba, logic eb, logic ean);
    logic [7:0] na, nb;
    @(negedge clk);
    a_in = ai; b_in = bi; cap_a = ca; cap_b = cb;
    sel_a2b = sab; sel_b2a = sba; en_b = eb; en_a_n = ean;
    #1;
    na = exp_a_res();
    nb = exp_b_res();
    chk(req, a_out, en_a_n ? 8'h00 : na);
    chk(req, b_out, en_b ? nb : 8'h00);
    chk("R5", {7'd0, a_oe}, {7'd0, ~en_a_n});
    chk("R5", {7'd0, b_oe}, {7'd0, en_b});
    @(posedge clk);
    m_hold = na;
    if (ca) m_ra = na;
    if (cb) m_rb = nb;
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step("R1", 8'hAA, 8'h55, 0, 0, 1, 1, 1, 0);     // stored both after reset: 00
    step("R5", 8'h12, 8'h34, 0, 0, 0, 0, 0, 1);     // isolated
    step("R2", 8'h5A, 8'hC3, 1, 1, 0, 0, 0, 1);     // capture inputs while isolated
    step("R10", 8'hFF, 8'hFF, 0, 0, 1, 1, 1, 0);    // both stored
    step("R3", 8'h3C, 8'h00, 0, 0, 0, 0, 1, 1);     // live A to B
    step("R3", 8'h3C, 8'h00, 0, 0, 1, 0, 1, 1);     // stored A to B
    step("R4", 8'h00, 8'h7E, 0, 0, 0, 0, 0, 0);     // live B to A
    step("R4", 8'h00, 8'h7E, 0, 0, 0, 1, 0, 0);     // stored B to A
    step("R8", 8'h96, 8'h01, 1, 1, 0, 0, 1, 1);     // loopback A into B
    step("R8", 8'h00, 8'h00, 0, 0, 1, 1, 1, 0);
    step("R8", 8'h02, 8'h69, 1, 1, 0, 0, 0, 0);     // loopback B into A
    step("R8", 8'h00, 8'h00, 0, 0, 1, 1, 1, 0);
    step("R2", 8'hA1, 8'hB2, 1, 0, 0, 0, 0, 1);
    step("R2", 8'hA1, 8'hB2, 0, 1, 0, 0, 0, 1);
    step("R9", 8'h00, 8'h00, 1, 1, 1, 1, 1, 0);     // simultaneous with stored selects
    step("R9", 8'h00, 8'h00, 0, 0, 1, 1, 1, 0);     // swapped
    step("R7", 8'h11, 8'h22, 0, 0, 0, 0, 1, 1);     // A resolves to 11
    for (int i = 0; i < 4; i++)
      step("R7", 8'(i * 37), 8'(i * 91), 0, 0, 0, 0, 1, 0);
    step("R7", 8'hEE, 8'hDD, 1, 1, 0, 0, 1, 0);     // capture latched value
    step("R7", 8'h00, 8'h00, 0, 0, 1, 1, 1, 0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step("R6", 8'($urandom), 8'($urandom), r[0], r[1], r[2], r[3], r[4], r[5]);
    end
    finish_run();
  end
endmodule